// File: doc/BRIEF.md
# Mode-Gated Shared Interrupt Controller

This block gathers the event sources of a packet radio into three groups (transmit, receive and system) and merges them onto a single interrupt pin. Each source has a sticky status bit and its own enable bit. An event pulse always sets its status bit, whether the source is enabled or not. A status register clears itself when it is read. Software can therefore wait on the interrupt pin, or it can ignore the pin and poll the status registers.

The radio mode input masks whole groups without touching the stored enable bits. While transmitting, every receive source is kept off the pin. While receiving, every transmit source is kept off the pin. System sources always reach the pin. The pin polarity is programmable, and so is the drive style: push-pull, or open-drain emulated with a level and an output enable that a pad cell consumes.

Top module: `radio_irq_merge`

## Requirements
- R1: After reset, all enable bits, status bits and configuration bits read 0. The pin is then active-low push-pull and inactive: level 1, output enable 1.
- R2: An event pulse on a source sets that source's status bit at the next clock edge, whether or not the source is enabled. The bit stays set until its register is read.
- R3: A read of a status register (addresses 3 = transmit, 4 = receive, 5 = system) returns the bits as they were before the read, on `reg_rdata_o`, one cycle after the read strobe. The same edge clears those bits, except for any bit whose event arrives in the same cycle as the read, which stays set.
- R4: The interrupt is active exactly when some source has both its status bit and its enable bit set and its group is not masked by the mode.
- R5: Mode is encoded as 2'b01 = transmit, 2'b10 = receive, and 2'b00 or 2'b11 = idle. In transmit mode the whole receive group is masked. In receive mode the whole transmit group is masked. In idle mode no group is masked.
- R6: A mode change leaves the stored enable registers (addresses 0 = transmit, 1 = receive, 2 = system) unchanged, and they read back as written.
- R7: System sources are never masked, in any mode.
- R8: Configuration bit 0 at address 6 selects the polarity: 1 means active-high, 0 means active-low. In push-pull drive the level is the asserted level when the interrupt is active, and its inverse otherwise.
- R9: Configuration bit 1 at address 6 selects open-drain when it is 1. In open-drain drive the level always shows the asserted level, and the output enable is 1 only while the interrupt is active. In push-pull drive the output enable is always 1.
- R10: Writes to the status addresses have no effect. Enable writes keep only the bits that exist: 4 transmit, 4 receive and 3 system sources by default. Configuration writes keep only bits 1:0. Unused bits, and address 7, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| radio_mode_i | input | 2 | Radio mode (01 transmit, 10 receive, else idle) |
| tx_event_i | input | N_TX | Transmit-group event pulses |
| rx_event_i | input | N_RX | Receive-group event pulses |
| sys_event_i | input | N_SYS | System-group event pulses |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, valid the cycle after a read strobe |
| irq_level_o | output | 1 | Interrupt pin level |
| irq_oe_o | output | 1 | Interrupt pin output enable |

## Verification
The merge is tried four ways:
- Events on disabled sources, which separate the status path from the pin path.
- Events on enabled sources in each of the four mode codes, which separate the transmit and receive masks and show that system sources always pass.
- Reads that coincide with fresh events, which show whether clear-on-read can drop a new event.
- All four polarity and drive combinations, with the interrupt both active and inactive, which separate the level logic from the output-enable logic.

A long stretch of seeded random events, modes and register accesses then compares every cycle's pin and read data against a reference model kept in the bench.

// File: rtl/radio_irq_pkg.sv
// Package: shared mode encoding, register addresses and pin configuration type
// for the mode-gated interrupt merge. Assumes a 3-bit register address space.
package radio_irq_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'b00,
        MODE_TX   = 2'b01,
        MODE_RX   = 2'b10,
        MODE_RSVD = 2'b11
    } radio_mode_e;

    localparam int GROUPS   = 3;
    localparam int GRP_TX   = 0;
    localparam int GRP_RX   = 1;
    localparam int GRP_SYS  = 2;

    // Enable registers sit at 0..2, status registers at 3..5, config at 6.
    localparam int ENABLE_BASE = 0;
    localparam int STATUS_BASE = 3;
    localparam int CONFIG_ADDR = 6;

    typedef struct packed {
        logic open_drain;
        logic act_high;
    } pin_cfg_t;

endpackage

// File: rtl/irq_src_bank.sv
// Module: one interrupt group. It holds the enable register and the sticky
// status register for SRC_N sources and raises a request when an enabled,
// set source exists and the group gate is open.
// Assumes: event pulses are synchronous to clk; SRC_N <= DATA_W.
module irq_src_bank #(
    parameter int SRC_N  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  ev_i,
    input  logic              en_we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              st_rd_i,
    input  logic              gate_i,
    output logic [DATA_W-1:0] en_o,
    output logic [DATA_W-1:0] st_o,
    output logic              req_o
);

    logic [SRC_N-1:0] en_q;
    logic [SRC_N-1:0] st_q;
    logic [SRC_N-1:0] pend;

    // Enable register: loaded only by an explicit write, keeps existing bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (en_we_i)
            en_q <= wdata_i[SRC_N-1:0];
    end

    // Sticky status: a read clears, but an event in the same cycle wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= (st_rd_i ? '0 : st_q) | ev_i;
    end

    // Request: any set and enabled source, passed through the mode gate.
    always_comb begin
        pend  = st_q & en_q;
        req_o = gate_i && (pend != '0);
        en_o  = DATA_W'(en_q);
        st_o  = DATA_W'(st_q);
    end

    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i != '0) |=> ((st_q & $past(ev_i)) == $past(ev_i)));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_rd_i) |=> ((st_q & $past(st_q)) == $past(st_q)));

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_rd_i && ev_i == '0) |=> (st_q == '0));

    assert_en_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_we_i) |=> $stable(en_q));

    assert_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_i) |-> !req_o);

endmodule

// File: rtl/irq_reg_port.sv
// Module: register access port. It decodes write and read strobes into
// per-group enable loads and status clears, holds the pin configuration,
// and returns read data one cycle after the read strobe.
// Assumes: one access per strobe; a write to a status address is dropped.
module irq_reg_port
    import radio_irq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_i,
    input  logic                           rd_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [DATA_W-1:0]              wdata_i,
    input  logic [GROUPS-1:0][DATA_W-1:0]  en_i,
    input  logic [GROUPS-1:0][DATA_W-1:0]  st_i,
    output logic [GROUPS-1:0]              en_we_o,
    output logic [GROUPS-1:0]              st_rd_o,
    output pin_cfg_t                       cfg_o,
    output logic [DATA_W-1:0]              rdata_o
);

    pin_cfg_t          cfg_q;
    logic              cfg_we;
    logic [DATA_W-1:0] rd_mux;

    // Strobe decode: one enable load or status clear per group address.
    always_comb begin
        for (int g = 0; g < GROUPS; g++) begin
            en_we_o[g] = wr_i && (addr_i == ADDR_W'(ENABLE_BASE + g));
            st_rd_o[g] = rd_i && (addr_i == ADDR_W'(STATUS_BASE + g));
        end
        cfg_we = wr_i && (addr_i == ADDR_W'(CONFIG_ADDR));
    end

    // Configuration register: polarity and drive style.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (cfg_we)
            cfg_q <= pin_cfg_t'(wdata_i[1:0]);
    end

    // Read mux: pre-clear values, unused addresses read zero.
    always_comb begin
        rd_mux = '0;
        for (int g = 0; g < GROUPS; g++) begin
            if (addr_i == ADDR_W'(ENABLE_BASE + g)) rd_mux = en_i[g];
            if (addr_i == ADDR_W'(STATUS_BASE + g)) rd_mux = st_i[g];
        end
        if (addr_i == ADDR_W'(CONFIG_ADDR)) rd_mux = DATA_W'(cfg_q);
    end

    // Read data register: captured on the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_o <= '0;
        else if (rd_i)
            rdata_o <= rd_mux;
    end

    assign cfg_o = cfg_q;

    assert_one_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_rd_o));

    assert_cfg_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we) |=> $stable(cfg_q));

endmodule

// File: rtl/irq_pin_drv.sv
// Module: pin driver. It applies the polarity after the merge and emulates
// open-drain by driving only the asserted level through the output enable.
// Assumes: active_i is the merged interrupt request, active-high.
module irq_pin_drv
    import radio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     active_i,
    input  pin_cfg_t cfg_i,
    output logic     level_o,
    output logic     oe_o
);

    // Drive selection: push-pull always drives, open-drain only when asserting.
    always_comb begin
        if (cfg_i.open_drain) begin
            level_o = cfg_i.act_high;
            oe_o    = active_i;
        end else begin
            level_o = active_i ? cfg_i.act_high : !cfg_i.act_high;
            oe_o    = 1'b1;
        end
    end

    assert_pp_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_i.open_drain) |-> oe_o);

    assert_od_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.open_drain && !active_i) |-> !oe_o);

    assert_idle_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_i.open_drain && !active_i) |-> (level_o != cfg_i.act_high));

endmodule

// File: rtl/radio_irq_merge.sv
// Module: top of the mode-gated shared interrupt controller. It instantiates
// one source bank per group, derives the group gates from the radio mode,
// ORs the requests and hands the result to the pin driver.
// Assumes: N_TX, N_RX and N_SYS are each no larger than DATA_W.
module radio_irq_merge
    import radio_irq_pkg::*;
#(
    parameter int N_TX   = 4,
    parameter int N_RX   = 4,
    parameter int N_SYS  = 3,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        radio_mode_i,
    input  logic [N_TX-1:0]   tx_event_i,
    input  logic [N_RX-1:0]   rx_event_i,
    input  logic [N_SYS-1:0]  sys_event_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_level_o,
    output logic              irq_oe_o
);

    radio_mode_e                   mode;
    logic [GROUPS-1:0][DATA_W-1:0] ev_pad;
    logic [GROUPS-1:0][DATA_W-1:0] en_w;
    logic [GROUPS-1:0][DATA_W-1:0] st_w;
    logic [GROUPS-1:0]             en_we;
    logic [GROUPS-1:0]             st_rd;
    logic [GROUPS-1:0]             gate;
    logic [GROUPS-1:0]             req;
    logic                          irq_active;
    pin_cfg_t                      cfg;

    // Event padding and mode gating: system group is never gated.
    always_comb begin
        mode          = radio_mode_e'(radio_mode_i);
        ev_pad[GRP_TX]  = DATA_W'(tx_event_i);
        ev_pad[GRP_RX]  = DATA_W'(rx_event_i);
        ev_pad[GRP_SYS] = DATA_W'(sys_event_i);
        gate[GRP_TX]    = (mode != MODE_RX);
        gate[GRP_RX]    = (mode != MODE_TX);
        gate[GRP_SYS]   = 1'b1;
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_bank
        localparam int W = (g == GRP_TX) ? N_TX : (g == GRP_RX) ? N_RX : N_SYS;
        irq_src_bank #(
            .SRC_N  (W),
            .DATA_W (DATA_W)
        ) bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .ev_i    (ev_pad[g][W-1:0]),
            .en_we_i (en_we[g]),
            .wdata_i (reg_wdata_i),
            .st_rd_i (st_rd[g]),
            .gate_i  (gate[g]),
            .en_o    (en_w[g]),
            .st_o    (st_w[g]),
            .req_o   (req[g])
        );
    end

    irq_reg_port #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr_i),
        .rd_i    (reg_rd_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .en_i    (en_w),
        .st_i    (st_w),
        .en_we_o (en_we),
        .st_rd_o (st_rd),
        .cfg_o   (cfg),
        .rdata_o (reg_rdata_o)
    );

    // Merge: one shared request from all group requests.
    assign irq_active = |req;

    irq_pin_drv pin_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (irq_active),
        .cfg_i    (cfg),
        .level_o  (irq_level_o),
        .oe_o     (irq_oe_o)
    );

    assert_sys_ungated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req[GRP_SYS] |-> irq_active);

    assert_tx_masks_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_TX) |-> !req[GRP_RX]);

endmodule

// File: tb/radio_irq_merge_tb_top.sv
module radio_irq_merge_tb_top;

    localparam logic [7:0] M_TX  = 8'h0F;
    localparam logic [7:0] M_RX  = 8'h0F;
    localparam logic [7:0] M_SYS = 8'h07;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_d = 2'b00;
    logic [3:0] tx_ev = '0;
    logic [3:0] rx_ev = '0;
    logic [2:0] sys_ev = '0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_level, irq_oe;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [7:0] m_en [3];
    logic [7:0] m_st [3];
    logic [1:0] m_cfg;

    always #5 clk = ~clk;

    radio_irq_merge dut_i (
        .clk(clk), .rst_n(rst_n), .radio_mode_i(mode_d),
        .tx_event_i(tx_ev), .rx_event_i(rx_ev), .sys_event_i(sys_ev),
        .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_level_o(irq_level), .irq_oe_o(irq_oe)
    );

    function automatic logic [7:0] grp_mask(input int g);
        return (g == 0) ? M_TX : (g == 1) ? M_RX : M_SYS;
    endfunction

    function automatic logic [7:0] model_read(input logic [2:0] a);
        if (a <= 3'd2) return m_en[a];
        if (a <= 3'd5) return m_st[a - 3'd3];
        if (a == 3'd6) return {6'b0, m_cfg};
        return 8'h00;
    endfunction

    function automatic logic model_active(input logic [1:0] m);
        logic gtx, grx;
        gtx = (m != 2'b10);
        grx = (m != 2'b01);
        return (gtx && ((m_st[0] & m_en[0]) != 0)) ||
               (grx && ((m_st[1] & m_en[1]) != 0)) ||
               ((m_st[2] & m_en[2]) != 0);
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: drive, advance model, check pins and any read data.
    task automatic cycle(input logic [1:0] m, input logic [7:0] etx, input logic [7:0] erx,
                         input logic [7:0] esys, input logic w, input logic r,
                         input logic [2:0] a, input logic [7:0] wd, input string tag);
        logic [7:0] rv;
        logic [7:0] ev [3];
        logic act, exp_lvl, exp_oe;
        mode_d = m; tx_ev = etx[3:0]; rx_ev = erx[3:0]; sys_ev = esys[2:0];
        wr = w; rd = r; addr = a; wdata = wd;
        ev[0] = etx & M_TX; ev[1] = erx & M_RX; ev[2] = esys & M_SYS;
        rv = model_read(a);
        @(posedge clk);
        #1;
        for (int g = 0; g < 3; g++) begin
            if (r && a == 3'(3 + g)) m_st[g] = ev[g];
            else m_st[g] = m_st[g] | ev[g];
            if (w && a == 3'(g)) m_en[g] = wd & grp_mask(g);
        end
        if (w && a == 3'd6) m_cfg = wd[1:0];
        if (r) check({tag, " R3 R10 read"}, rdata, rv);
        act = model_active(m);
        if (m_cfg[1]) begin exp_lvl = m_cfg[0]; exp_oe = act; end
        else begin exp_lvl = act ? m_cfg[0] : !m_cfg[0]; exp_oe = 1'b1; end
        check({tag, " R4 R8 level"}, {7'b0, irq_level}, {7'b0, exp_lvl});
        check({tag, " R4 R9 oe"}, {7'b0, irq_oe}, {7'b0, exp_oe});
    endtask

    task automatic idle(input logic [1:0] m, input string tag);
        cycle(m, 0, 0, 0, 0, 0, 3'd0, 8'h00, tag);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d, input string tag);
        cycle(mode_d, 0, 0, 0, 1, 0, a, d, tag);
    endtask

    task automatic rd_reg(input logic [2:0] a, input string tag);
        cycle(mode_d, 0, 0, 0, 0, 1, a, 8'h00, tag);
    endtask

    initial begin
        for (int g = 0; g < 3; g++) begin m_en[g] = 0; m_st[g] = 0; end
        m_cfg = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state of pin and registers.
        check("R1 level", {7'b0, irq_level}, 8'h01);
        check("R1 oe", {7'b0, irq_oe}, 8'h01);
        for (int a = 0; a < 8; a++) rd_reg(3'(a), "R1");

        // R2: event on disabled source sets status, pin stays inactive.
        cycle(2'b00, 8'h02, 8'h01, 8'h04, 0, 0, 0, 0, "R2");
        idle(2'b00, "R2");
        rd_reg(3'd3, "R2");
        // R3: second read finds cleared status.
        rd_reg(3'd3, "R3");
        // R3: event coinciding with read survives.
        cycle(2'b00, 0, 8'h08, 0, 0, 1, 3'd4, 0, "R3 same-cycle");
        rd_reg(3'd4, "R3 survived");
        rd_reg(3'd5, "R3 sys");

        // R4: enable then fire, all four polarity/drive combos.
        wr_reg(3'd0, 8'hFF, "R10 mask");
        rd_reg(3'd0, "R10 mask");
        cycle(2'b00, 8'h01, 0, 0, 0, 0, 0, 0, "R4 active");
        for (int c = 0; c < 4; c++) begin
            wr_reg(3'd6, 8'hFC | 8'(c), "R8 R9 cfg");
            idle(2'b00, "R8 R9 active");
        end
        rd_reg(3'd6, "R10 cfg");
        rd_reg(3'd3, "R4 clear");
        idle(2'b00, "R9 inactive");
        wr_reg(3'd6, 8'h00, "R8");

        // R5 R6 R7: mode gating with both groups pending.
        wr_reg(3'd1, 8'h0F, "R6");
        cycle(2'b01, 0, 8'h04, 0, 0, 0, 0, 0, "R5 tx masks rx");
        idle(2'b10, "R5 rx passes");
        cycle(2'b10, 8'h02, 0, 0, 0, 0, 0, 0, "R5 both pend");
        idle(2'b01, "R5 tx only");
        rd_reg(3'd1, "R6 rx enable kept");
        rd_reg(3'd0, "R6 tx enable kept");
        rd_reg(3'd3, "R5 clr tx");
        idle(2'b10, "R5 rx mode rx pend");
        rd_reg(3'd4, "R5 clr rx");
        idle(2'b11, "R5 idle none");
        wr_reg(3'd2, 8'h07, "R7");
        cycle(2'b01, 0, 0, 8'h04, 0, 0, 0, 0, "R7 sys in tx");
        idle(2'b10, "R7 sys in rx");
        // R10: writes to status ignored.
        wr_reg(3'd5, 8'h00, "R10 status write");
        rd_reg(3'd5, "R10 status write ignored");
        rd_reg(3'd7, "R10 unused addr");

        // Random phase with fixed seed.
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] e0, e1, e2, wd;
            logic w, r;
            logic [2:0] a;
            e0 = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
            e1 = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
            e2 = ($urandom % 6 == 0) ? 8'($urandom) : 8'h00;
            w = ($urandom % 5 == 0);
            r = ($urandom % 3 == 0);
            a = 3'($urandom);
            wd = 8'($urandom);
            cycle(2'($urandom), e0, e1, e2, w, r, a, wd, "R4 R5 R7 random");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule